// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the hardwired control unit of a one-instruction-per-clock processor core. It sees the 6-bit primary opcode and the 6-bit function field of the instruction currently being executed. From these it drives the datapath steering signals in the same cycle. These cover the choice of destination register, the choice of the second ALU operand, the register-file write-back source, the data-memory read and write strobes, and the next-PC selection. It also drives a 4-bit operation code for the ALU. The block holds no state: every output is a Boolean function of the present inputs.

ALU operation selection works in two levels. Opcode 0 marks the register-register group, and for that group the function field chooses the operation. Every other legal opcode chooses its operation directly. The ALU sends back a single condition bit. The decoder gates that bit with the conditional-branch opcodes to form the branch-target select. Any opcode outside the supported set, and any register-register function outside the supported set, raises an illegal flag. When that flag is high, all writes to architectural state are suppressed.

Encodings used throughout are as follows. Opcodes:
- 0: register-register group
- 2: jump
- 4, 5, 6, 7: branch if equal, not equal, at-or-below zero, above zero
- 8, 12, 13, 14: immediate add, and, or, xor
- 35: word load
- 43: word store

Function codes:
- 0x20: add
- 0x22: subtract
- 0x24: and
- 0x25: or
- 0x26: xor
- 0x27: nor

ALU codes:
- 0: add
- 1: subtract
- 2: and
- 3: or
- 4: xor
- 5: nor
- 8: equal
- 9: not equal
- 10: signed rs <= 0
- 11: signed rs > 0

Top module: `sc_ctrl_decode`

## Requirements
- R1: `dst_sel_rd_o` is 1 exactly when the opcode is 0, and 0 for every other opcode.
- R2: `alu_src_imm_o` is 1 exactly when the opcode is nonzero and is neither 4 nor 5. This rule also holds for unsupported opcodes.
- R3: `mem_rd_o` and `load_to_reg_o` are 1 only for opcode 35. `mem_we_o` is 1 only for opcode 43.
- R4: `reg_we_o` is 1 for the supported register-register functions, the immediate opcodes 8/12/13/14 and the load opcode 35. It is 0 for the store, the branches 4 to 7 and the jump 2.
- R5: `pc_sel_jump_o` is 1 only for opcode 2, whatever the value of `cond_met_i`.
- R6: `pc_sel_branch_o` is 1 exactly when the opcode is in 4 to 7 and `cond_met_i` is 1. For all other opcodes `cond_met_i` has no effect on any output.
- R7: For opcode 0 the ALU code follows the function field: 0x20 gives 0, 0x22 gives 1, 0x24 gives 2, 0x25 gives 3, 0x26 gives 4, 0x27 gives 5.
- R8: The ALU code is 0 for opcodes 8, 35 and 43, 2 for opcode 12, 3 for opcode 13 and 4 for opcode 14.
- R9: The ALU code is 8 for opcode 4 and 9 for opcode 5. It is 10 for opcode 6 and 11 for opcode 7. Codes 10 and 11 compare rs as a signed value against zero and do not use rt.
- R10: `illegal_o` is 1 for any unsupported opcode, and for opcode 0 with an unsupported function field. In both cases `reg_we_o`, `mem_we_o`, `mem_rd_o`, both PC selects and the ALU code are all 0.
- R11: For nonzero opcodes the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode of the current instruction |
| funct_i | input | 6 | Function field, used only for opcode 0 |
| cond_met_i | input | 1 | Branch condition result from the ALU |
| dst_sel_rd_o | output | 1 | Write register taken from rd rather than rt |
| alu_src_imm_o | output | 1 | Second ALU operand is the sign-extended immediate |
| load_to_reg_o | output | 1 | Write-back value comes from memory |
| reg_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Data-memory read strobe |
| mem_we_o | output | 1 | Data-memory write strobe |
| pc_sel_jump_o | output | 1 | Next PC is the 26-bit jump target |
| pc_sel_branch_o | output | 1 | Next PC is the branch target |
| alu_op_o | output | 4 | ALU operation code |
| illegal_o | output | 1 | Unsupported instruction |

## Verification
The two functions that can coincide are branch-target selection and the ALU condition feedback. When `cond_met_i` is raised on an opcode that is not a branch, for example on a store or on an illegal instruction, it must not reach the next-PC selection or any other output. The bench applies every opcode against every function value with the condition bit both low and high. Every output field is compared against values derived from the encoding tables in the requirements. This shows that the condition only ever steers the PC for opcodes 4 to 7, and that the illegal flag never coexists with a state write.

// File: rtl/sc_ctl_pkg.sv
package sc_ctl_pkg;

    localparam int unsigned OPC_W = 6;
    localparam int unsigned FN_W  = 6;
    localparam int unsigned AOP_W = 4;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_BLEZ  = 6'd6;
    localparam logic [OPC_W-1:0] OPC_BGTZ  = 6'd7;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_XOR = 6'h26;
    localparam logic [FN_W-1:0] FN_NOR = 6'h27;

    typedef enum logic [AOP_W-1:0] {
        AOP_ADD  = 4'd0,
        AOP_SUB  = 4'd1,
        AOP_AND  = 4'd2,
        AOP_OR   = 4'd3,
        AOP_XOR  = 4'd4,
        AOP_NOR  = 4'd5,
        AOP_CEQ  = 4'd8,
        AOP_CNE  = 4'd9,
        AOP_CLEZ = 4'd10,
        AOP_CGTZ = 4'd11
    } alu_op_e;

    typedef enum logic [2:0] {
        K_REG,
        K_IMM,
        K_LOAD,
        K_STORE,
        K_BRANCH,
        K_JUMP,
        K_BAD
    } ikind_e;

endpackage

// File: rtl/sc_opc_class.sv
module sc_opc_class
    import sc_ctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ikind_e           kind_o,
    output alu_op_e          dir_op_o
);

    always_comb begin
        kind_o   = K_BAD;
        dir_op_o = AOP_ADD;
        unique case (opcode_i)
            OPC_REG:   kind_o = K_REG;
            OPC_JMP:   kind_o = K_JUMP;
            OPC_BEQ:   begin kind_o = K_BRANCH; dir_op_o = AOP_CEQ;  end
            OPC_BNE:   begin kind_o = K_BRANCH; dir_op_o = AOP_CNE;  end
            OPC_BLEZ:  begin kind_o = K_BRANCH; dir_op_o = AOP_CLEZ; end
            OPC_BGTZ:  begin kind_o = K_BRANCH; dir_op_o = AOP_CGTZ; end
            OPC_ADDI:  begin kind_o = K_IMM;    dir_op_o = AOP_ADD;  end
            OPC_ANDI:  begin kind_o = K_IMM;    dir_op_o = AOP_AND;  end
            OPC_ORI:   begin kind_o = K_IMM;    dir_op_o = AOP_OR;   end
            OPC_XORI:  begin kind_o = K_IMM;    dir_op_o = AOP_XOR;  end
            OPC_LOAD:  kind_o = K_LOAD;
            OPC_STORE: kind_o = K_STORE;
            default:   kind_o = K_BAD;
        endcase
    end

endmodule

// File: rtl/sc_alu_sel.sv
module sc_alu_sel
    import sc_ctl_pkg::*;
(
    input  ikind_e          kind_i,
    input  alu_op_e         dir_op_i,
    input  logic [FN_W-1:0] funct_i,
    output alu_op_e         alu_op_o,
    output logic            fn_bad_o
);

    alu_op_e fn_op;
    logic    fn_known;

    always_comb begin
        fn_op    = AOP_ADD;
        fn_known = 1'b1;
        unique case (funct_i)
            FN_ADD:  fn_op = AOP_ADD;
            FN_SUB:  fn_op = AOP_SUB;
            FN_AND:  fn_op = AOP_AND;
            FN_OR:   fn_op = AOP_OR;
            FN_XOR:  fn_op = AOP_XOR;
            FN_NOR:  fn_op = AOP_NOR;
            default: fn_known = 1'b0;
        endcase
    end

    always_comb begin
        fn_bad_o = 1'b0;
        unique case (kind_i)
            K_REG: begin
                alu_op_o = fn_op;
                fn_bad_o = !fn_known;
            end
            K_IMM, K_BRANCH:  alu_op_o = dir_op_i;
            K_LOAD, K_STORE:  alu_op_o = AOP_ADD;
            default:          alu_op_o = AOP_ADD;
        endcase
    end

endmodule

// File: rtl/sc_pc_steer.sv
module sc_pc_steer
    import sc_ctl_pkg::*;
(
    input  ikind_e kind_i,
    input  logic   cond_met_i,
    output logic   jump_o,
    output logic   branch_o
);

    always_comb begin
        jump_o   = (kind_i == K_JUMP);
        branch_o = (kind_i == K_BRANCH) && cond_met_i;
    end

endmodule

// File: rtl/sc_ctrl_decode.sv
module sc_ctrl_decode
    import sc_ctl_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    input  logic       cond_met_i,
    output logic       dst_sel_rd_o,
    output logic       alu_src_imm_o,
    output logic       load_to_reg_o,
    output logic       reg_we_o,
    output logic       mem_rd_o,
    output logic       mem_we_o,
    output logic       pc_sel_jump_o,
    output logic       pc_sel_branch_o,
    output logic [3:0] alu_op_o,
    output logic       illegal_o
);

    ikind_e  kind;
    alu_op_e dir_op;
    alu_op_e sel_op;
    logic    fn_bad;
    logic    bad;

    sc_opc_class u_class (
        .opcode_i (opcode_i),
        .kind_o   (kind),
        .dir_op_o (dir_op)
    );

    sc_alu_sel u_alu_sel (
        .kind_i   (kind),
        .dir_op_i (dir_op),
        .funct_i  (funct_i),
        .alu_op_o (sel_op),
        .fn_bad_o (fn_bad)
    );

    sc_pc_steer u_pc (
        .kind_i     (kind),
        .cond_met_i (cond_met_i),
        .jump_o     (pc_sel_jump_o),
        .branch_o   (pc_sel_branch_o)
    );

    always_comb begin
        bad             = (kind == K_BAD) || fn_bad;
        illegal_o       = bad;
        dst_sel_rd_o    = (opcode_i == OPC_REG);
        alu_src_imm_o   = (opcode_i != OPC_REG) && (opcode_i != OPC_BEQ)
                          && (opcode_i != OPC_BNE);
        load_to_reg_o   = (kind == K_LOAD);
        mem_rd_o        = (kind == K_LOAD);
        mem_we_o        = (kind == K_STORE);
        reg_we_o        = !bad && ((kind == K_REG) || (kind == K_IMM)
                          || (kind == K_LOAD));
        alu_op_o        = sel_op;
    end

endmodule

// File: rtl/sc_ctrl_decode_chk.sv
module sc_ctrl_decode_chk (
    input logic [5:0] opcode_i,
    input logic [5:0] funct_i,
    input logic       cond_met_i,
    input logic       dst_sel_rd_o,
    input logic       alu_src_imm_o,
    input logic       load_to_reg_o,
    input logic       reg_we_o,
    input logic       mem_rd_o,
    input logic       mem_we_o,
    input logic       pc_sel_jump_o,
    input logic       pc_sel_branch_o,
    input logic [3:0] alu_op_o,
    input logic       illegal_o
);

    always_comb begin
        if (!$isunknown({opcode_i, funct_i, cond_met_i})) begin
            a_r1_rd_no_imm: assert (!dst_sel_rd_o || !alu_src_imm_o)
                else $error("R1: rd destination with immediate operand");
            a_r3_load_pair: assert (load_to_reg_o == mem_rd_o)
                else $error("R3: load strobes disagree");
            a_r3_mem_excl: assert (!(mem_rd_o && mem_we_o))
                else $error("R3: memory read and write together");
            a_r4_write_excl: assert (!(reg_we_o && mem_we_o))
                else $error("R4: register and memory write together");
            a_r5_pc_onehot: assert ($onehot0({pc_sel_jump_o, pc_sel_branch_o}))
                else $error("R5: both PC selects high");
            a_r6_branch_cond: assert (!pc_sel_branch_o || cond_met_i)
                else $error("R6: branch select without condition");
            a_r8_store_adds: assert (!mem_we_o || alu_op_o == 4'd0)
                else $error("R8: store without add");
            a_r10_illegal_quiet: assert (!illegal_o || (!reg_we_o && !mem_we_o))
                else $error("R10: illegal instruction writes state");
        end
    end

endmodule

bind sc_ctrl_decode sc_ctrl_decode_chk chk_i (
    .opcode_i        (opcode_i),
    .funct_i         (funct_i),
    .cond_met_i      (cond_met_i),
    .dst_sel_rd_o    (dst_sel_rd_o),
    .alu_src_imm_o   (alu_src_imm_o),
    .load_to_reg_o   (load_to_reg_o),
    .reg_we_o        (reg_we_o),
    .mem_rd_o        (mem_rd_o),
    .mem_we_o        (mem_we_o),
    .pc_sel_jump_o   (pc_sel_jump_o),
    .pc_sel_branch_o (pc_sel_branch_o),
    .alu_op_o        (alu_op_o),
    .illegal_o       (illegal_o)
);

// File: tb/sc_ctrl_decode_tb_top.sv
module sc_ctrl_decode_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [5:0] opcode;
    logic [5:0] funct;
    logic       cond;
    logic       dst_sel_rd, alu_src_imm, load_to_reg, reg_we;
    logic       mem_rd, mem_we, pc_jump, pc_branch, illegal;
    logic [3:0] alu_op;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    sc_ctrl_decode dut_i (
        .opcode_i        (opcode),
        .funct_i         (funct),
        .cond_met_i      (cond),
        .dst_sel_rd_o    (dst_sel_rd),
        .alu_src_imm_o   (alu_src_imm),
        .load_to_reg_o   (load_to_reg),
        .reg_we_o        (reg_we),
        .mem_rd_o        (mem_rd),
        .mem_we_o        (mem_we),
        .pc_sel_jump_o   (pc_jump),
        .pc_sel_branch_o (pc_branch),
        .alu_op_o        (alu_op),
        .illegal_o       (illegal)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s op=%0d fn=%0h c=%0d actual=%0d expected=%0d",
                     req, what, opcode, funct, cond, act, exp);
        end
    endtask

    task automatic apply(input int op, input int fn, input int c);
        int  e_alu;
        bit  e_bad;
        bit  is_br;
        bit  legal_wr;
        opcode = 6'(op);
        funct  = 6'(fn);
        cond   = c[0];
        @(negedge clk);
        vectors++;
        is_br = (op >= 4 && op <= 7);
        e_bad = 1'b0;
        e_alu = 0;
        legal_wr = 1'b0;
        if (op == 0) begin
            case (fn)
                'h20: e_alu = 0;
                'h22: e_alu = 1;
                'h24: e_alu = 2;
                'h25: e_alu = 3;
                'h26: e_alu = 4;
                'h27: e_alu = 5;
                default: e_bad = 1'b1;
            endcase
            legal_wr = !e_bad;
        end else begin
            case (op)
                2, 43: ;
                4: e_alu = 8;
                5: e_alu = 9;
                6: e_alu = 10;
                7: e_alu = 11;
                8, 35: begin e_alu = 0; legal_wr = 1'b1; end
                12: begin e_alu = 2; legal_wr = 1'b1; end
                13: begin e_alu = 3; legal_wr = 1'b1; end
                14: begin e_alu = 4; legal_wr = 1'b1; end
                default: e_bad = 1'b1;
            endcase
        end
        // R1 destination select
        chk("R1", "dst_sel_rd", dst_sel_rd, op == 0);
        // R2 immediate operand select
        chk("R2", "alu_src_imm", alu_src_imm, op != 0 && op != 4 && op != 5);
        // R3 memory strobes
        chk("R3", "mem_rd", mem_rd, op == 35);
        chk("R3", "load_to_reg", load_to_reg, op == 35);
        chk("R3", "mem_we", mem_we, op == 43);
        // R4 register write (R10 forces low when illegal)
        chk("R4", "reg_we", reg_we, legal_wr);
        // R5 jump select
        chk("R5", "pc_sel_jump", pc_jump, op == 2);
        // R6 branch select gated by condition
        chk("R6", "pc_sel_branch", pc_branch, is_br && c != 0);
        // R7 R8 R9 alu code
        if (op == 0)
            chk("R7", "alu_op", alu_op, e_alu);
        else if (is_br)
            chk("R9", "alu_op", alu_op, e_alu);
        else
            chk("R8", "alu_op", alu_op, e_alu);
        // R10 illegal flag
        chk("R10", "illegal", illegal, e_bad);
    endtask

    // R11: funct ignored for nonzero opcodes, checked by the full funct sweep
    // at every opcode against funct-independent expectations above.
    initial begin
        opcode = '0;
        funct  = '0;
        cond   = 1'b0;
        @(posedge clk);
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                for (int c = 0; c < 2; c++) begin
                    if (!done) apply(op, fn, c);
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG_LIMIT && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WDOG_LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule